// File: doc/BRIEF.md
# Power-Mode-Aware Chip Reset Controller

This block drives the chip-wide active-low reset and keeps a record of what caused the most recent one. Which reset sources count depends on the current power mode: run, wait, doze or stop. A reset source is one of these: power-on, the external reset pin, clock or lock loss from the PLL monitor, a watchdog timeout, or a software request. Once a reset is taken, the block releases it cleanly on the clock. The release first passes through a two-flop synchroniser and then through a fixed hold count.

The pin is handled in one of two ways. While the clock runs in run, wait and doze, a press on the pin must last four sampled clocks before it is honoured, so short glitches are filtered out. In stop mode that filter is skipped and the pin pulls the reset down at once, with no clock edge needed. The block also holds the power-mode register, which software writes. Any reset sets that register back to run. When a reset ends a low-power mode, the block raises a one-cycle wake flag.

Top module: `rst_mode_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_n_o` is low with no clock edge needed, `cause_o` is 6'b000001, `mode_o` is run (2'b00) and `wake_o` is low.
- R2: `rst_n_o` rises at the tenth rising clock edge after the last reset source goes away (2 synchroniser stages, then 8 hold clocks). For a source that is sampled on an edge, that edge counts as edge zero.
- R3: In run, wait and doze the pin `ext_rst_n` passes through a two-flop synchroniser. A reset is issued on the fourth consecutive edge that samples the synchronised pin low. A low run of three samples or fewer has no effect, and the count restarts from zero whenever the pin is seen high.
- R4: In stop mode (`mode_o` = 2'b11), a low level on `ext_rst_n` drives `rst_n_o` low at once. The next rising edge records the external-pin cause.
- R5: Loss of clock (`loc_flag`) resets the chip only when `pll_active` and `loc_rst_en` are both high. Loss of lock (`lol_flag`) resets it only when `pll_active` and `lol_rst_en` are both high. Either one applies in every mode.
- R6: `wdt_timeout` resets the chip only when `wdt_enabled` is high and the mode is not stop.
- R7: `sw_rst_req` is ignored while `cpu_active` is low.
- R8: `cause_o` is one-hot and is written with each reset: bit0 power-on, bit1 pin, bit2 clock loss, bit3 lock loss, bit4 watchdog, bit5 software. When several sources fire together, priority runs from bit1 down to bit5. Only power-on clears the register to bit0.
- R9: `mode_we` loads `mode_sel` into `mode_o` (2'b00 run, 2'b01 wait, 2'b10 doze, 2'b11 stop) only while `rst_n_o` is high. Any reset sets `mode_o` back to run, and a write made during reset is lost.
- R10: `wake_o` is high for exactly the one cycle after a reset is taken in a mode other than run. Power-on never raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_n | input | 1 | External reset pin, active low |
| mode_we | input | 1 | Write strobe for the power mode |
| mode_sel | input | 2 | Power mode to write |
| pll_active | input | 1 | PLL is running |
| loc_flag | input | 1 | Loss-of-clock indication |
| loc_rst_en | input | 1 | Allow loss-of-clock reset |
| lol_flag | input | 1 | Loss-of-lock indication |
| lol_rst_en | input | 1 | Allow loss-of-lock reset |
| wdt_timeout | input | 1 | Watchdog expired |
| wdt_enabled | input | 1 | Watchdog is still enabled |
| sw_rst_req | input | 1 | Software reset request |
| cpu_active | input | 1 | CPU is executing |
| rst_n_o | output | 1 | Chip reset, active low |
| wake_o | output | 1 | One-cycle flag: a reset ended a low-power mode |
| cause_o | output | 6 | One-hot cause of the last reset |
| mode_o | output | 2 | Current power mode |

## Verification
The case that is hardest to reach is the stop-mode pin path. There, a pin pulse that falls between two clock edges has to pull the reset down with no edge to sample it, and the following edge must still record the pin as the cause. The bench first puts the block into stop mode through the mode write port. It then drives a pulse of a few nanoseconds in the middle of a clock period, reads `rst_n_o` while that pulse is still low, and checks the cause, wake and mode outputs after the next edge. Pin runs of three samples, and of three samples split by a single high sample, are driven as well. These confirm that the qualifier never fires early.

// File: rtl/rst_mode_ctrl.sv
module rst_mode_ctrl #(
  parameter int PIN_QUAL = 4,
  parameter int HOLD     = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ext_rst_n,
  input  logic       mode_we,
  input  logic [1:0] mode_sel,
  input  logic       pll_active,
  input  logic       loc_flag,
  input  logic       loc_rst_en,
  input  logic       lol_flag,
  input  logic       lol_rst_en,
  input  logic       wdt_timeout,
  input  logic       wdt_enabled,
  input  logic       sw_rst_req,
  input  logic       cpu_active,
  output logic       rst_n_o,
  output logic       wake_o,
  output logic [5:0] cause_o,
  output logic [1:0] mode_o
);
  localparam int PW = $clog2(PIN_QUAL + 1);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [1:0] M_RUN  = 2'd0;
  localparam logic [1:0] M_STOP = 2'd3;

  logic [1:0]    mode_q;
  logic          p1, p2;
  logic [PW-1:0] pcnt;
  logic          s1, s2;
  logic [HW-1:0] hcnt;
  logic [5:0]    cause_q;
  logic          wake_q;

  wire stop_m   = (mode_q == M_STOP);
  wire arst_n   = por_n & ~(stop_m & ~ext_rst_n);
  wire ext_trig = ~p2 & (pcnt >= PW'(PIN_QUAL - 1));
  wire loc_trig = pll_active & loc_rst_en & loc_flag;
  wire lol_trig = pll_active & lol_rst_en & lol_flag;
  wire wdt_trig = wdt_timeout & wdt_enabled & ~stop_m;
  wire sw_trig  = sw_rst_req & cpu_active;
  wire stop_hit = stop_m & ~s1;
  wire any_trig = ext_trig | loc_trig | lol_trig | wdt_trig | sw_trig;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) {p2, p1} <= 2'b11;
    else        {p2, p1} <= {p1, ext_rst_n};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                      pcnt <= '0;
    else if (p2)                     pcnt <= '0;
    else if (pcnt != PW'(PIN_QUAL))  pcnt <= pcnt + 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)       {s2, s1} <= 2'b00;
    else if (any_trig) {s2, s1} <= 2'b00;
    else               {s2, s1} <= {s1, 1'b1};

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)                  hcnt <= '0;
    else if (any_trig || !s2)     hcnt <= '0;
    else if (hcnt != HW'(HOLD))   hcnt <= hcnt + 1'b1;

  assign rst_n_o = (hcnt == HW'(HOLD));

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                               mode_q <= M_RUN;
    else if (any_trig || stop_hit || !rst_n_o) mode_q <= M_RUN;
    else if (mode_we)                         mode_q <= mode_sel;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)                    cause_q <= 6'b000001;
    else if (stop_hit || ext_trig) cause_q <= 6'b000010;
    else if (loc_trig)             cause_q <= 6'b000100;
    else if (lol_trig)             cause_q <= 6'b001000;
    else if (wdt_trig)             cause_q <= 6'b010000;
    else if (sw_trig)              cause_q <= 6'b100000;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) wake_q <= 1'b0;
    else        wake_q <= (mode_q != M_RUN) & (any_trig | stop_hit);

  assign wake_o  = wake_q;
  assign cause_o = cause_q;
  assign mode_o  = mode_q;

  // R8
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause_o) == 1);

  // R9
  mode_run_in_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n_o |=> mode_o == M_RUN);

  // R4
  stop_pin_chk: assert property (@(posedge clk) disable iff (!por_n)
    (stop_m && !ext_rst_n) |-> !rst_n_o);

  // R3
  ext_qual_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cause_o[1]) |-> ($past(mode_q) == M_STOP || $past(pcnt) >= PW'(PIN_QUAL - 1)));

  // R5
  loc_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cause_o[2]) |-> $past(pll_active && loc_rst_en));

  // R6
  wdt_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cause_o[4]) |-> ($past(wdt_enabled) && $past(mode_q) != M_STOP));

  // R7
  sw_gate_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(cause_o[5]) |-> $past(cpu_active));

  // R10
  wake_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    wake_o |-> (mode_o == M_RUN && !rst_n_o));
endmodule

// File: tb/rst_mode_ctrl_tb.sv
module rst_mode_ctrl_tb;
  localparam int CLK_NS = 10;

  logic clk = 0;
  logic por_n = 0, ext_rst_n = 1, mode_we = 0;
  logic [1:0] mode_sel = 0;
  logic pll_active = 0, loc_flag = 0, loc_rst_en = 0, lol_flag = 0, lol_rst_en = 0;
  logic wdt_timeout = 0, wdt_enabled = 0, sw_rst_req = 0, cpu_active = 0;
  logic rst_n_o, wake_o;
  logic [5:0] cause_o;
  logic [1:0] mode_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  rst_mode_ctrl u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .mode_we(mode_we), .mode_sel(mode_sel),
    .pll_active(pll_active), .loc_flag(loc_flag), .loc_rst_en(loc_rst_en),
    .lol_flag(lol_flag), .lol_rst_en(lol_rst_en), .wdt_timeout(wdt_timeout),
    .wdt_enabled(wdt_enabled), .sw_rst_req(sw_rst_req), .cpu_active(cpu_active),
    .rst_n_o(rst_n_o), .wake_o(wake_o), .cause_o(cause_o), .mode_o(mode_o));

  // {mode[1:0], pll, loc_en, loc, lol_en, lol, wdt_to, wdt_en, sw, cpu, exp_rst, exp_cause[5:0], exp_wake}
  localparam logic [18:0] VEC [14] = '{
    19'b00_1_1_1_0_0_0_0_0_0_1_000100_0,  // R5 loc run
    19'b00_0_1_1_0_0_0_0_0_0_0_000001_0,  // R5 loc, pll off
    19'b01_1_0_1_0_0_0_0_0_0_0_000001_0,  // R5 loc, enable off
    19'b10_1_0_0_1_1_0_0_0_0_1_001000_1,  // R5 lol doze
    19'b00_0_0_0_1_1_0_0_0_0_0_000001_0,  // R5 lol, pll off
    19'b01_0_0_0_0_0_1_1_0_0_1_010000_1,  // R6 wdt wait
    19'b10_0_0_0_0_0_1_0_0_0_0_000001_0,  // R6 wdt disabled
    19'b11_0_0_0_0_0_1_1_0_0_0_000001_0,  // R6 wdt in stop
    19'b00_0_0_0_0_0_1_1_0_0_1_010000_0,  // R6 wdt run
    19'b00_0_0_0_0_0_0_0_1_1_1_100000_0,  // R7 sw with cpu
    19'b00_0_0_0_0_0_0_0_1_0_0_000001_0,  // R7 sw, cpu idle
    19'b01_0_0_0_0_0_0_0_1_0_0_000001_0,  // R7 sw in wait, cpu idle
    19'b00_1_1_1_0_0_1_1_1_1_1_000100_0,  // R8 priority
    19'b11_1_1_1_0_0_0_0_0_0_1_000100_1   // R10 wake from stop
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic do_por();
    @(negedge clk);
    por_n = 0; ext_rst_n = 1; mode_we = 0;
    {pll_active, loc_flag, loc_rst_en, lol_flag, lol_rst_en} = '0;
    {wdt_timeout, wdt_enabled, sw_rst_req, cpu_active} = '0;
    #1;
    chk("R1 rst", rst_n_o, 0);
    repeat (2) @(negedge clk);
    chk("R1 cause", cause_o, 6'b000001);
    chk("R1 mode", mode_o, 0);
    chk("R1 wake", wake_o, 0);
    por_n = 1;
    repeat (9) @(negedge clk);
    chk("R2 held", rst_n_o, 0);
    @(negedge clk);
    chk("R2 release", rst_n_o, 1);
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    mode_we = 1; mode_sel = m;
    @(negedge clk);
    mode_we = 0;
    chk("R9 mode write", mode_o, m);
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // Vector walk over gated sources
    for (int i = 0; i < 14; i++) begin
      do_por();
      set_mode(VEC[i][18:17]);
      {pll_active, loc_rst_en, loc_flag, lol_rst_en, lol_flag,
       wdt_timeout, wdt_enabled, sw_rst_req, cpu_active} = VEC[i][16:8];
      @(negedge clk);
      {pll_active, loc_rst_en, loc_flag, lol_rst_en, lol_flag,
       wdt_timeout, wdt_enabled, sw_rst_req, cpu_active} = '0;
      chk("R5/R6/R7 rst", rst_n_o, !VEC[i][7]);
      chk("R8 cause", cause_o, VEC[i][6:1]);
      chk("R10 wake", wake_o, VEC[i][0]);
      if (VEC[i][7]) begin
        chk("R9 mode cleared", mode_o, 0);
        @(negedge clk);
        chk("R10 wake one cycle", wake_o, 0);
        repeat (8) @(negedge clk);
        chk("R2 hold after trigger", rst_n_o, 0);
        @(negedge clk);
        chk("R2 release after trigger", rst_n_o, 1);
      end else begin
        chk("R9 mode kept", mode_o, VEC[i][18:17]);
      end
    end

    // R3: three-sample pulse ignored
    do_por();
    @(negedge clk); ext_rst_n = 0;
    repeat (3) @(negedge clk); ext_rst_n = 1;
    repeat (8) @(negedge clk);
    chk("R3 short pulse rst", rst_n_o, 1);
    chk("R3 short pulse cause", cause_o, 6'b000001);

    // R3: restart of the qualifier
    @(negedge clk); ext_rst_n = 0;
    repeat (3) @(negedge clk); ext_rst_n = 1;
    @(negedge clk); ext_rst_n = 0;
    repeat (3) @(negedge clk); ext_rst_n = 1;
    repeat (8) @(negedge clk);
    chk("R3 restart rst", rst_n_o, 1);
    chk("R3 restart cause", cause_o, 6'b000001);

    // R3/R10: four samples in wait mode
    set_mode(2'd1);
    @(negedge clk); ext_rst_n = 0;
    repeat (5) @(negedge clk);
    chk("R3 before fourth sample", rst_n_o, 1);
    @(negedge clk);
    chk("R3 fourth sample rst", rst_n_o, 0);
    chk("R8 pin cause", cause_o, 6'b000010);
    chk("R10 wake from wait", wake_o, 1);
    ext_rst_n = 1;
    repeat (20) @(negedge clk);
    chk("R2 release after pin", rst_n_o, 1);

    // R8: cause replaced by a later non-POR reset
    cpu_active = 1; sw_rst_req = 1;
    @(negedge clk);
    sw_rst_req = 0;
    chk("R8 cause replaced", cause_o, 6'b100000);
    // R9: write during reset is lost
    mode_we = 1; mode_sel = 2'd2;
    @(negedge clk);
    mode_we = 0;
    repeat (12) @(negedge clk);
    chk("R9 write in reset lost", mode_o, 0);
    chk("R2 release after sw", rst_n_o, 1);

    // R4: asynchronous pin in stop
    set_mode(2'd3);
    @(negedge clk);
    #2 ext_rst_n = 0;
    #1 chk("R4 async assert", rst_n_o, 0);
    #1 ext_rst_n = 1;
    @(negedge clk);
    chk("R4 cause pin", cause_o, 6'b000010);
    chk("R10 wake from stop", wake_o, 1);
    chk("R9 mode back to run", mode_o, 0);
    @(negedge clk);
    chk("R10 wake drops", wake_o, 0);
    repeat (12) @(negedge clk);
    chk("R2 release after stop", rst_n_o, 1);

    // R1: POR clears cause mid-run
    do_por();
    chk("R8 por clears cause", cause_o, 6'b000001);

    finish_run();
  end
endmodule